// File: doc/BRIEF.md
# Register Map CRC Integrity Monitor

This block guards a small configuration register file against silent corruption. It owns the read port of that file. When software turns the monitor on, it reads every register once, folds the bytes into a CRC and keeps the result as the reference signature. From then on, a timebase sets the pace for background scans. Each scan recomputes the signature and compares it with the reference. A mismatch means some register changed without a legitimate write, and a sticky error flag rises. That flag is meant to feed a chip-level summary of digital faults.

A legitimate write to the register file is reported on a one-cycle write-event input. The monitor then takes a fresh reference from the updated contents, so intended changes never count as faults. If a write arrives while a scan is in progress, that scan is abandoned and no verdict is drawn from it. Turning the monitor off stops all scanning and clears the flag.

The signature is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, shifted most-significant bit first. One byte is processed per clock.

Top module: `regmap_crc_monitor`

## Requirements
- R1: After reset, `crc_err_o` is 0, the monitor is off and `scan_addr_o` is 0.
- R2: When `mon_en_i` is sampled high while the monitor is off, the block starts a reference pass at the same clock edge. During that pass `scan_addr_o` steps through 0, 1, …, NUM_REGS-1, one address per clock. `scan_data_i` is taken combinationally in the same cycle as its address. A pass uses CRC-16, polynomial 0x1021, initial value 0xFFFF, MSB first.
- R3: While enabled and idle, a background scan starts once every SCAN_TICKS cycles in which `tick_i` is high. If the scan's CRC differs from the reference, `crc_err_o` rises one clock after the scan completes.
- R4: A register map that does not change never raises `crc_err_o`, however many scans run.
- R5: A single flipped bit is detected at any address, including the first (0) and the last (NUM_REGS-1).
- R6: A `wr_evt_i` pulse while enabled starts a new reference pass over the current contents. A change that comes with such a pulse never raises `crc_err_o`.
- R7: A `wr_evt_i` pulse during a background scan aborts that scan and starts a reference pass. An interrupted scan never raises `crc_err_o`.
- R8: Once raised, `crc_err_o` stays high for as long as `mon_en_i` stays high.
- R9: When `mon_en_i` is sampled low, `crc_err_o` is 0 from the next clock. While the monitor is off, no scan runs and `scan_addr_o` stays 0.
- R10: The scan period advances only in cycles with `tick_i` high. With `tick_i` held low, no background scan starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_en_i | input | 1 | Monitor enable (configuration bit) |
| wr_evt_i | input | 1 | One-cycle pulse on each legitimate register write |
| tick_i | input | 1 | Timebase enable for the scan period counter |
| scan_addr_o | output | $clog2(NUM_REGS) | Read address into the register file |
| scan_data_i | input | 8 | Read data for `scan_addr_o`, same cycle |
| crc_err_o | output | 1 | Sticky register-map corruption flag |

## Verification
Some properties are checked on every cycle. The scan address advances by one per clock during a pass. A write while enabled always moves the controller into a reference pass. The error flag rises only at the completion of an uninterrupted scan, stays up while enabled and drops after disable. The period counter freezes without a tick and wraps after expiry. Other behaviours can only be shown by the bench's scenarios, because they depend on the contents of the register file: whether a corrupted first or last byte is actually caught, whether a write-accompanied change stays silent, and whether an aborted scan over corrupted data leaves the flag low.

// File: rtl/crcmon_pkg.sv
// Package for the register map CRC monitor: controller states and the
// byte-wide CRC-16 update (polynomial 0x1021, MSB first).
// Assumes 8-bit registers and a 16-bit signature.
package crcmon_pkg;
    localparam int BYTE_W = 8;
    localparam int SIG_W  = 16;
    localparam logic [SIG_W-1:0] SIG_POLY = 16'h1021;
    localparam logic [SIG_W-1:0] SIG_SEED = 16'hFFFF;

    typedef enum logic [1:0] {
        MON_OFF  = 2'd0,
        MON_REF  = 2'd1,
        MON_IDLE = 2'd2,
        MON_SCAN = 2'd3
    } mon_state_e;

    // Fold one byte into the running signature, most significant bit first.
    function automatic logic [SIG_W-1:0] sig_fold(input logic [SIG_W-1:0] sig,
                                                  input logic [BYTE_W-1:0] b);
        logic [SIG_W-1:0] s;
        logic fb;
        s = sig;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = s[SIG_W-1] ^ b[i];
            s  = {s[SIG_W-2:0], 1'b0} ^ (fb ? SIG_POLY : '0);
        end
        return s;
    endfunction
endpackage

// File: rtl/crcmon_timer.sv
// Scan period timer: counts tick-qualified cycles while the monitor is on.
// It raises expire_o for one cycle every PERIOD ticks. It is cleared while
// the monitor is off. Assumes PERIOD >= 2.
module crcmon_timer #(
    parameter int PERIOD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int CNT_W = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Expiry is the tick that lands on the last count of the period.
    assign expire_o = en_i && tick_i && (cnt_q == LIMIT);

    // Advance on each tick, wrap at the limit, clear while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LIMIT) ? '0 : cnt_q + 1'b1;
        end
    end

    assert_wrap_after_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (cnt_q == '0));
    assert_frozen_without_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/crcmon_engine.sv
// Signature engine: after start_i it walks addresses 0..NUM_REGS-1, one per
// clock, and folds the returned byte into the CRC. It pulses done_o in the
// cycle after the last byte, with sig_o holding the result. start_i restarts
// a pass at any time. abort_i stops it and takes priority.
// Assumes read data is valid combinationally in the cycle of its address.
module crcmon_engine
    import crcmon_pkg::*;
#(
    parameter int NUM_REGS = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        abort_i,
    output logic [$clog2(NUM_REGS)-1:0] addr_o,
    input  logic [BYTE_W-1:0]           data_i,
    output logic [SIG_W-1:0]            sig_o,
    output logic                        done_o
);
    localparam int ADDR_W = $clog2(NUM_REGS);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_REGS - 1);

    logic              busy_q;
    logic              done_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SIG_W-1:0]  sig_q;

    assign addr_o = addr_q;
    assign sig_o  = sig_q;
    assign done_o = done_q;

    // Pass sequencer: seed, walk addresses, fold bytes, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            addr_q <= '0;
            sig_q  <= SIG_SEED;
        end else begin
            done_q <= 1'b0;
            if (abort_i) begin
                busy_q <= 1'b0;
                addr_q <= '0;
            end else if (start_i) begin
                busy_q <= 1'b1;
                addr_q <= '0;
                sig_q  <= SIG_SEED;
            end else if (busy_q) begin
                sig_q <= sig_fold(sig_q, data_i);
                if (addr_q == LAST) begin
                    busy_q <= 1'b0;
                    addr_q <= '0;
                    done_q <= 1'b1;
                end else begin
                    addr_q <= addr_q + 1'b1;
                end
            end
        end
    end

    assert_addr_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !start_i && !abort_i && addr_q != LAST) |=> (addr_q == $past(addr_q) + 1'b1));
    assert_idle_addr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (addr_q == '0));
endmodule

// File: rtl/crcmon_ctrl.sv
// Monitor controller: sequences reference passes and background scans, keeps
// the reference signature and owns the sticky error flag. Writes always win
// over scans. A scan that a write interrupts yields no verdict.
module crcmon_ctrl
    import crcmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             wr_evt_i,
    input  logic             expire_i,
    input  logic             done_i,
    input  logic [SIG_W-1:0] sig_i,
    output logic             start_o,
    output logic             abort_o,
    output logic             err_o
);
    mon_state_e       state_q;
    logic [SIG_W-1:0] ref_q;
    logic             err_q;

    assign err_o   = err_q;
    assign abort_o = !en_i;

    // Decide when the engine begins a new pass.
    always_comb begin
        start_o = 1'b0;
        if (en_i) begin
            unique case (state_q)
                MON_OFF:  start_o = 1'b1;
                MON_REF:  start_o = wr_evt_i;
                MON_IDLE: start_o = wr_evt_i || expire_i;
                MON_SCAN: start_o = wr_evt_i;
                default:  start_o = 1'b0;
            endcase
        end
    end

    // State, reference capture and error verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MON_OFF;
            ref_q   <= '0;
            err_q   <= 1'b0;
        end else if (!en_i) begin
            state_q <= MON_OFF;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                MON_OFF: state_q <= MON_REF;
                MON_REF: begin
                    if (!wr_evt_i && done_i) begin
                        ref_q   <= sig_i;
                        state_q <= MON_IDLE;
                    end
                end
                MON_IDLE: begin
                    if (wr_evt_i)      state_q <= MON_REF;
                    else if (expire_i) state_q <= MON_SCAN;
                end
                MON_SCAN: begin
                    if (wr_evt_i) begin
                        state_q <= MON_REF;
                    end else if (done_i) begin
                        if (sig_i != ref_q) err_q <= 1'b1;
                        state_q <= MON_IDLE;
                    end
                end
                default: state_q <= MON_OFF;
            endcase
        end
    end

    assert_off_clears_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !err_o);
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && en_i) |=> err_o);
    assert_err_only_from_full_scan_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(state_q == MON_SCAN && done_i && !wr_evt_i));
    assert_write_refreshes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && wr_evt_i && state_q != MON_OFF) |=> (state_q == MON_REF));
endmodule

// File: rtl/regmap_crc_monitor.sv
// Register map CRC integrity monitor (top). It scans an external register
// file through a combinational read port. It takes a reference signature on
// enable and after each write, then rescans every SCAN_TICKS timebase ticks
// and raises a sticky flag on mismatch.
// Assumes scan_data_i reflects scan_addr_o within the same cycle.
module regmap_crc_monitor
    import crcmon_pkg::*;
#(
    parameter int NUM_REGS   = 64,
    parameter int SCAN_TICKS = 1000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mon_en_i,
    input  logic                        wr_evt_i,
    input  logic                        tick_i,
    output logic [$clog2(NUM_REGS)-1:0] scan_addr_o,
    input  logic [BYTE_W-1:0]           scan_data_i,
    output logic                        crc_err_o
);
    logic             expire;
    logic             start;
    logic             abort;
    logic             done;
    logic [SIG_W-1:0] sig;

    crcmon_timer #(.PERIOD(SCAN_TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (mon_en_i),
        .tick_i   (tick_i),
        .expire_o (expire)
    );

    crcmon_engine #(.NUM_REGS(NUM_REGS)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .abort_i (abort),
        .addr_o  (scan_addr_o),
        .data_i  (scan_data_i),
        .sig_o   (sig),
        .done_o  (done)
    );

    crcmon_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (mon_en_i),
        .wr_evt_i (wr_evt_i),
        .expire_i (expire),
        .done_i   (done),
        .sig_i    (sig),
        .start_o  (start),
        .abort_o  (abort),
        .err_o    (crc_err_o)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!crc_err_o && scan_addr_o == '0));
endmodule

// File: tb/regmap_crc_monitor_test.sv
// Directed bench: models the register file as an array, corrupts it silently
// or through announced writes, and watches the error flag and scan address.
module regmap_crc_monitor_test;
    localparam int NREG   = 64;
    localparam int PERIOD = 200;
    localparam int AW     = $clog2(NREG);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mon_en = 1'b0;
    logic          wr_evt = 1'b0;
    logic          tick = 1'b1;
    logic [AW-1:0] scan_addr;
    logic [7:0]    scan_data;
    logic          crc_err;
    logic [7:0]    regs [NREG];

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    assign scan_data = regs[scan_addr];

    regmap_crc_monitor #(.NUM_REGS(NREG), .SCAN_TICKS(PERIOD)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mon_en_i    (mon_en),
        .wr_evt_i    (wr_evt),
        .tick_i      (tick),
        .scan_addr_o (scan_addr),
        .scan_data_i (scan_data),
        .crc_err_o   (crc_err)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_write(input int idx, input logic [7:0] val);
        regs[idx] = val;
        wr_evt = 1'b1;
        step(1);
        wr_evt = 1'b0;
    endtask

    task automatic t_reset;
        for (int i = 0; i < NREG; i++) regs[i] = 8'(i * 7 + 3);
        rst_n = 1'b0;
        step(5);
        rst_n = 1'b1;
        step(1);
        check(crc_err == 1'b0, "R1", "err after reset", int'(crc_err), 0);
        check(scan_addr == '0, "R1", "addr after reset", int'(scan_addr), 0);
    endtask

    task automatic t_clean;
        mon_en = 1'b1;
        step(1);
        check(scan_addr == 0, "R2", "first pass address", int'(scan_addr), 0);
        step(10);
        check(scan_addr == 10, "R2", "pass address after 10 clocks", int'(scan_addr), 10);
        step(3 * PERIOD + 100);
        check(crc_err == 1'b0, "R4", "no error on unchanged map", int'(crc_err), 0);
    endtask

    task automatic t_last_and_disable;
        regs[NREG-1] = regs[NREG-1] ^ 8'h01;
        step(PERIOD + 80);
        check(crc_err == 1'b1, "R5", "flip at last address detected", int'(crc_err), 1);
        step(2 * PERIOD);
        check(crc_err == 1'b1, "R8", "error held while enabled", int'(crc_err), 1);
        mon_en = 1'b0;
        step(1);
        check(crc_err == 1'b0, "R9", "error cleared one clock after disable", int'(crc_err), 0);
        step(3 * PERIOD);
        check(crc_err == 1'b0 && scan_addr == 0, "R9", "quiet while off (addr)",
              int'(scan_addr), 0);
        regs[NREG-1] = regs[NREG-1] ^ 8'h01;
    endtask

    task automatic t_first;
        mon_en = 1'b1;
        step(100);
        regs[0] = regs[0] ^ 8'h80;
        step(PERIOD + 80);
        check(crc_err == 1'b1, "R5", "flip at address 0 detected", int'(crc_err), 1);
        check(crc_err == 1'b1, "R3", "scan mismatch raises error", int'(crc_err), 1);
        mon_en = 1'b0;
        step(2);
    endtask

    task automatic t_write;
        mon_en = 1'b1;
        step(100);
        pulse_write(20, 8'hA5);
        step(3 * PERIOD + 100);
        check(crc_err == 1'b0, "R6", "announced write is not an error", int'(crc_err), 0);
    endtask

    task automatic t_abort;
        int guard;
        regs[5] = regs[5] ^ 8'h10;
        guard = 0;
        while (scan_addr != 40 && guard < 4 * PERIOD) begin
            step(1);
            guard++;
        end
        check(scan_addr == 40, "R7", "scan reached mid map", int'(scan_addr), 40);
        wr_evt = 1'b1;
        step(1);
        wr_evt = 1'b0;
        step(3 * PERIOD + 100);
        check(crc_err == 1'b0, "R7", "aborted scan gives no error", int'(crc_err), 0);
    endtask

    task automatic t_tick;
        tick = 1'b0;
        step(80);
        regs[10] = regs[10] ^ 8'h04;
        step(4 * PERIOD);
        check(crc_err == 1'b0, "R10", "no scan without tick", int'(crc_err), 0);
        tick = 1'b1;
        step(PERIOD + 80);
        check(crc_err == 1'b1, "R10", "scan resumes with tick", int'(crc_err), 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_clean();
                t_last_and_disable();
                t_first();
                t_write();
                t_abort();
                t_tick();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual=expired expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule